// File: doc/BRIEF.md
# Register ALU with Flag Update

This block is the combinational arithmetic and logic unit behind the register-to-register instruction group of a compact 16-bit instruction encoding. A 4-bit operation code picks one of sixteen functions. Each function takes a 32-bit first operand, which is also the destination, and a 32-bit second operand. The unit returns a 32-bit result, a strobe that says whether the result is written back, and new values for the negative, zero, carry and overflow flags.

The surrounding pipeline supplies the current carry and overflow flags. The carry feeds the carry-chained add and subtract and is passed through by operations that do not define a carry. The overflow flag is passed through by operations that do not define an overflow. Shift and rotate distances come from the low byte of the second operand. The multiply returns the low word of the full product in the same cycle.

Top module: `reg_alu_flags`

## Requirements
- R1: Bitwise functions, selected by opSel: 4'h0 gives opA & opB, 4'h1 gives opA ^ opB, 4'hC gives opA | opB, 4'hE gives opA & ~opB, and 4'hF gives ~opB.
- R2: 4'h5 gives opA + opB + carryIn. 4'h6 gives opA - opB - (1 - carryIn). In both, flagC is the carry out of bit 31, which for the subtract means that no borrow occurred.
- R3: 4'h9 gives 0 - opB. flagC is 1 only when opB is zero, and flagV is 1 only when opB is 32'h8000_0000.
- R4: 4'h8 (AND), 4'hA (opA - opB) and 4'hB (opA + opB) update the flags but hold writeEn low. All other codes drive writeEn high. The result port always shows the internally computed value.
- R5: For every code, flagN equals result bit 31 and flagZ is 1 exactly when the result is zero.
- R6: For the add and subtract forms (4'h5, 4'h6, 4'h9, 4'hA, 4'hB), flagV is set on two's-complement overflow. For all other codes, flagV equals overflowIn.
- R7: For the bitwise codes (4'h0, 4'h1, 4'h8, 4'hC, 4'hE, 4'hF) and the multiply (4'hD), flagC equals carryIn.
- R8: 4'h2 shifts opA left and 4'h3 shifts it right logically, by n = opB[7:0]. For 0 < n < 32, flagC is the last bit shifted out. For n = 32, the result is 0 and flagC is opA[0] (left) or opA[31] (right). For n > 32, the result is 0 and flagC is 0.
- R9: 4'h4 shifts opA right arithmetically by n = opB[7:0]. For 0 < n < 32, flagC is the last bit shifted out. For n >= 32, every result bit and flagC equal opA[31].
- R10: 4'h7 rotates opA right by n = opB[7:0] modulo 32. When n is nonzero, flagC equals result bit 31. This includes nonzero multiples of 32, where the value is returned unrotated.
- R11: For all four shift and rotate codes, when opB[7:0] is zero the result equals opA and flagC equals carryIn, whatever opB[31:8] holds.
- R12: 4'hD gives the low 32 bits of opA * opB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand and destination value |
| opB | input | 32 | Second operand; bits [7:0] set the shift distance |
| opSel | input | 4 | Operation code |
| carryIn | input | 1 | Current carry flag |
| overflowIn | input | 1 | Current overflow flag |
| result | output | 32 | Computed value |
| writeEn | output | 1 | High when the result is to be written back |
| flagN | output | 1 | New negative flag |
| flagZ | output | 1 | New zero flag |
| flagC | output | 1 | New carry flag |
| flagV | output | 1 | New overflow flag |

## Verification
The assertions check several properties on every input change:
- writeEn follows the operation code.
- N and Z follow the result.
- The overflow flag passes through for the non-arithmetic codes.
- A zero shift distance leaves the value and carry untouched.
- The compare's carry matches an unsigned comparison of the operands.
- The complement and bit-clear values are correct.

Only the bench's scenarios show the exact shift-out carries at distances of 32 and beyond, rotate behaviour at multiples of 32, the carry-chained subtract, the overflow edges of negate and add, and the multiply's truncated product. These are checked against a bit-serial reference model under both directed and random operands.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND     = 4'h0,
    OP_XOR     = 4'h1,
    OP_SHL     = 4'h2,
    OP_SHR     = 4'h3,
    OP_SAR     = 4'h4,
    OP_ADDC    = 4'h5,
    OP_SUBC    = 4'h6,
    OP_ROTR    = 4'h7,
    OP_TEST    = 4'h8,
    OP_NEGATE  = 4'h9,
    OP_COMPARE = 4'hA,
    OP_COMPNEG = 4'hB,
    OP_OR      = 4'hC,
    OP_MULT    = 4'hD,
    OP_CLEAR   = 4'hE,
    OP_NOT     = 4'hF
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_LOGIC = 2'd0,
    RES_ARITH = 2'd1,
    RES_SHIFT = 2'd2,
    RES_MUL   = 2'd3
  } resSel_e;

  typedef enum logic [2:0] {
    LK_AND  = 3'd0,
    LK_XOR  = 3'd1,
    LK_OR   = 3'd2,
    LK_ANDN = 3'd3,
    LK_NOTB = 3'd4
  } logicKind_e;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RIGHT = 2'd1,
    SK_ARITH = 2'd2,
    SK_ROT   = 2'd3
  } shiftKind_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_FLAG = 2'd2
  } carrySel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSel_e    resSel;
    logicKind_e logicKind;
    shiftKind_e shiftKind;
    logic       zeroFirst;   // replace adder input A by zero
    logic       invSecond;   // complement adder input B
    carrySel_e  carrySel;
    logic       writeBack;
  } aluCtrl_t;

endpackage

// File: rtl/reg_alu_decode.sv
module reg_alu_decode
  import reg_alu_pkg::*;
(
  input  aluOp_e   opCode,
  output aluCtrl_t ctrl
);

  always_comb begin
    ctrl.resSel    = RES_LOGIC;
    ctrl.logicKind = LK_AND;
    ctrl.shiftKind = SK_LEFT;
    ctrl.zeroFirst = 1'b0;
    ctrl.invSecond = 1'b0;
    ctrl.carrySel  = CI_ZERO;
    ctrl.writeBack = 1'b1;
    unique case (opCode)
      OP_AND:     ctrl.logicKind = LK_AND;
      OP_XOR:     ctrl.logicKind = LK_XOR;
      OP_OR:      ctrl.logicKind = LK_OR;
      OP_CLEAR:   ctrl.logicKind = LK_ANDN;
      OP_NOT:     ctrl.logicKind = LK_NOTB;
      OP_TEST: begin
        ctrl.logicKind = LK_AND;
        ctrl.writeBack = 1'b0;
      end
      OP_SHL: begin
        ctrl.resSel    = RES_SHIFT;
        ctrl.shiftKind = SK_LEFT;
      end
      OP_SHR: begin
        ctrl.resSel    = RES_SHIFT;
        ctrl.shiftKind = SK_RIGHT;
      end
      OP_SAR: begin
        ctrl.resSel    = RES_SHIFT;
        ctrl.shiftKind = SK_ARITH;
      end
      OP_ROTR: begin
        ctrl.resSel    = RES_SHIFT;
        ctrl.shiftKind = SK_ROT;
      end
      OP_ADDC: begin
        ctrl.resSel   = RES_ARITH;
        ctrl.carrySel = CI_FLAG;
      end
      OP_SUBC: begin
        ctrl.resSel    = RES_ARITH;
        ctrl.invSecond = 1'b1;
        ctrl.carrySel  = CI_FLAG;
      end
      OP_NEGATE: begin
        ctrl.resSel    = RES_ARITH;
        ctrl.zeroFirst = 1'b1;
        ctrl.invSecond = 1'b1;
        ctrl.carrySel  = CI_ONE;
      end
      OP_COMPARE: begin
        ctrl.resSel    = RES_ARITH;
        ctrl.invSecond = 1'b1;
        ctrl.carrySel  = CI_ONE;
        ctrl.writeBack = 1'b0;
      end
      OP_COMPNEG: begin
        ctrl.resSel    = RES_ARITH;
        ctrl.writeBack = 1'b0;
      end
      OP_MULT:    ctrl.resSel = RES_MUL;
      default:    ctrl.writeBack = 1'b1;
    endcase
  end

endmodule

// File: rtl/reg_alu_shifter.sv
module reg_alu_shifter
  import reg_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     value,
  input  logic [AMT_W-1:0] amount,
  input  shiftKind_e       kind,
  input  logic             carryIn,
  output logic [W-1:0]     shifted,
  output logic             carryOut
);

  localparam int ROT_W = $clog2(W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

  logic [W:0]       leftWide;
  logic [W:0]       rightWide;
  logic [W:0]       sarWide;
  logic [AMT_W-1:0] sarAmount;
  logic [ROT_W-1:0] rotAmount;
  logic [ROT_W:0]   rotBack;
  logic [W-1:0]     rotated;

  // One extra bit on the exit side of each shifter catches the last bit out
  always_comb begin
    leftWide  = {1'b0, value} << amount;
    rightWide = {value, 1'b0} >> amount;
    sarAmount = (amount > FULL_AMT) ? FULL_AMT : amount;
    sarWide   = $signed({value, 1'b0}) >>> sarAmount;
    rotAmount = amount[ROT_W-1:0];
    rotBack   = (ROT_W+1)'(W) - {1'b0, rotAmount};
    rotated   = (value >> rotAmount) | (value << rotBack);
  end

  always_comb begin
    if (amount == '0) begin
      shifted  = value;
      carryOut = carryIn;
    end else begin
      unique case (kind)
        SK_LEFT: begin
          shifted  = leftWide[W-1:0];
          carryOut = leftWide[W];
        end
        SK_RIGHT: begin
          shifted  = rightWide[W:1];
          carryOut = rightWide[0];
        end
        SK_ARITH: begin
          shifted  = sarWide[W:1];
          carryOut = sarWide[0];
        end
        default: begin
          shifted  = rotated;
          carryOut = rotated[W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/reg_alu_datapath.sv
module reg_alu_datapath
  import reg_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  aluCtrl_t     ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic         overflowIn,
  output logic [W-1:0] result,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV
);

  logic [W-1:0] arithA;
  logic [W-1:0] arithB;
  logic         adderCin;
  logic [W:0]   sumWide;
  logic [W-1:0] sum;
  logic         sumCarry;
  logic         sumOvf;
  logic [W-1:0] logicRes;
  logic [W-1:0] product;
  logic [W-1:0] shiftRes;
  logic         shiftCarry;

  // Single shared adder: add, add with carry, subtracts and negate
  always_comb begin
    arithA = ctrl.zeroFirst ? '0 : opA;
    arithB = ctrl.invSecond ? ~opB : opB;
    unique case (ctrl.carrySel)
      CI_ONE:  adderCin = 1'b1;
      CI_FLAG: adderCin = carryIn;
      default: adderCin = 1'b0;
    endcase
    sumWide  = {1'b0, arithA} + {1'b0, arithB} + {{W{1'b0}}, adderCin};
    sum      = sumWide[W-1:0];
    sumCarry = sumWide[W];
    sumOvf   = (arithA[W-1] == arithB[W-1]) && (sum[W-1] != arithA[W-1]);
  end

  always_comb begin
    unique case (ctrl.logicKind)
      LK_XOR:  logicRes = opA ^ opB;
      LK_OR:   logicRes = opA | opB;
      LK_ANDN: logicRes = opA & ~opB;
      LK_NOTB: logicRes = ~opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb product = opA * opB;

  reg_alu_shifter #(
    .W     (W),
    .AMT_W (AMT_W)
  ) i_shifter (
    .value    (opA),
    .amount   (opB[AMT_W-1:0]),
    .kind     (ctrl.shiftKind),
    .carryIn  (carryIn),
    .shifted  (shiftRes),
    .carryOut (shiftCarry)
  );

  always_comb begin
    flagV = overflowIn;
    flagC = carryIn;
    unique case (ctrl.resSel)
      RES_ARITH: begin
        result = sum;
        flagC  = sumCarry;
        flagV  = sumOvf;
      end
      RES_SHIFT: begin
        result = shiftRes;
        flagC  = shiftCarry;
      end
      RES_MUL:   result = product;
      default:   result = logicRes;
    endcase
    flagN = result[W-1];
    flagZ = (result == '0);
  end

endmodule

// File: rtl/reg_alu_flags.sv
module reg_alu_flags
  import reg_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   opSel,
  input  logic         carryIn,
  input  logic         overflowIn,
  output logic [W-1:0] result,
  output logic         writeEn,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV
);

  aluCtrl_t ctrl;

  reg_alu_decode i_decode (
    .opCode (aluOp_e'(opSel)),
    .ctrl   (ctrl)
  );

  reg_alu_datapath #(
    .W     (W),
    .AMT_W (AMT_W)
  ) i_datapath (
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .overflowIn (overflowIn),
    .result     (result),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .flagC      (flagC),
    .flagV      (flagV)
  );

  assign writeEn = ctrl.writeBack;

endmodule

// File: rtl/reg_alu_flags_checker.sv
module reg_alu_flags_checker #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [3:0]   opSel,
  input logic         carryIn,
  input logic         overflowIn,
  input logic [W-1:0] result,
  input logic         writeEn,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagV
);

  logic flagOnly;
  logic nonArith;
  logic isShift;

  always_comb begin
    flagOnly = (opSel == 4'h8) || (opSel == 4'hA) || (opSel == 4'hB);
    nonArith = !((opSel == 4'h5) || (opSel == 4'h6) || (opSel == 4'h9) ||
                 (opSel == 4'hA) || (opSel == 4'hB));
    isShift  = (opSel == 4'h2) || (opSel == 4'h3) || (opSel == 4'h4) || (opSel == 4'h7);
  end

  always_comb begin
    assert_write_strobe_R4: assert (writeEn == !flagOnly);
    assert_zero_flag_R5: assert (flagZ == (result == '0));
    assert_neg_flag_R5: assert (flagN == result[W-1]);
    assert_v_passthrough_R6: assert (!nonArith || (flagV == overflowIn));
    assert_zero_shift_R11: assert (!(isShift && (opB[AMT_W-1:0] == '0)) ||
                                   ((result == opA) && (flagC == carryIn)));
    assert_compare_carry_R4: assert ((opSel != 4'hA) || (flagC == (opA >= opB)));
    assert_complement_R1: assert ((opSel != 4'hF) || (result == ~opB));
    assert_bitclear_R1: assert ((opSel != 4'hE) || (result == (opA & ~opB)));
  end

endmodule

bind reg_alu_flags reg_alu_flags_checker #(
  .W     (W),
  .AMT_W (AMT_W)
) i_checker (
  .opA        (opA),
  .opB        (opB),
  .opSel      (opSel),
  .carryIn    (carryIn),
  .overflowIn (overflowIn),
  .result     (result),
  .writeEn    (writeEn),
  .flagN      (flagN),
  .flagZ      (flagZ),
  .flagC      (flagC),
  .flagV      (flagV)
);

// File: tb/test_reg_alu_flags.sv
module test_reg_alu_flags;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = '0;
  logic        carryIn = 1'b0;
  logic        overflowIn = 1'b0;
  logic [31:0] result;
  logic        writeEn, flagN, flagZ, flagC, flagV;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #10 clk = ~clk;  // 50 MHz

  reg_alu_flags i_reg_alu_flags (
    .opA(opA), .opB(opB), .opSel(opSel), .carryIn(carryIn), .overflowIn(overflowIn),
    .result(result), .writeEn(writeEn), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV)
  );

  function automatic bit ovf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // Returns {writeEn, N, Z, C, V, result}
  function automatic logic [36:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] op, input logic ci, input logic vi);
    logic [31:0] r;
    logic c, v, we;
    logic [32:0] t;
    longint sa, sb, s;
    int n;
    r = '0; c = ci; v = vi; we = 1'b1;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    n = int'(b[7:0]);
    case (op)
      4'h0: r = a & b;
      4'h1: r = a ^ b;
      4'hC: r = a | b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h8: begin r = a & b; we = 1'b0; end
      4'hD: r = a * b;
      4'h5, 4'hB: begin
        t = {1'b0, a} + {1'b0, b} + ((op == 4'h5) ? 33'(ci) : 33'd0);
        r = t[31:0]; c = t[32];
        s = sa + sb + ((op == 4'h5) ? longint'(ci) : 0);
        v = ovf(s);
        if (op == 4'hB) we = 1'b0;
      end
      4'h6, 4'hA: begin
        t = (op == 4'h6) ? 33'(!ci) : 33'd0;
        r = a - b - t[31:0];
        c = ({1'b0, a} >= ({1'b0, b} + t));
        s = sa - sb - longint'(t);
        v = ovf(s);
        if (op == 4'hA) we = 1'b0;
      end
      4'h9: begin r = 32'd0 - b; c = (b == 0); v = ovf(-sb); end
      4'h2: begin r = a; for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end end
      4'h3: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end end
      4'h4: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
      default: begin
        r = a;
        for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
        if (n != 0) c = r[31];
      end
    endcase
    return {we, r[31], (r == 0), c, v, r};
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'h5, 4'h6:       return "R2";
      4'h9:             return "R3";
      4'h8, 4'hA, 4'hB: return "R4";
      4'h2, 4'h3:       return "R8";
      4'h4:             return "R9";
      4'h7:             return "R10";
      4'hD:             return "R12";
      default:          return "R1";
    endcase
  endfunction

  task automatic runCase(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                         input logic ci, input logic vi, input string tag);
    logic [36:0] exp, act;
    @(negedge clk);
    opA = a; opB = b; opSel = op; carryIn = ci; overflowIn = vi;
    #5;
    exp = model(a, b, op, ci, vi);
    act = {writeEn, flagN, flagZ, flagC, flagV, result};
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s op=%h a=%h b=%h ci=%b vi=%b actual={we,N,Z,C,V}=%b res=%h expected={we,N,Z,C,V}=%b res=%h",
               tag, op, a, b, ci, vi, act[36:32], act[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Initial state with all-zero inputs: AND of zeros is zero (R5)
    runCase(32'h0, 32'h0, 4'h0, 1'b0, 1'b0, "R5");
    // R1 bitwise
    runCase(32'hF0F0_1234, 32'h0FF0_FFFF, 4'hE, 1'b0, 1'b1, "R1");
    runCase(32'h0, 32'h0000_0000, 4'hF, 1'b1, 1'b0, "R1");
    runCase(32'hAAAA_5555, 32'hFFFF_0000, 4'h1, 1'b0, 1'b0, "R1");
    // R2 carry-chained
    runCase(32'd5, 32'd3, 4'h6, 1'b0, 1'b0, "R2");
    runCase(32'd3, 32'd3, 4'h6, 1'b0, 1'b0, "R2");
    runCase(32'hFFFF_FFFF, 32'h0, 4'h5, 1'b1, 1'b0, "R2");
    // R3 negate
    runCase(32'h1234, 32'h0, 4'h9, 1'b0, 1'b0, "R3");
    runCase(32'h0, 32'h8000_0000, 4'h9, 1'b0, 1'b0, "R3");
    // R4 flag-only
    runCase(32'd77, 32'd77, 4'hA, 1'b0, 1'b0, "R4");
    runCase(32'hFF00, 32'h00FF, 4'h8, 1'b1, 1'b1, "R4");
    // R6 overflow through the compare-negative add
    runCase(32'h7FFF_FFFF, 32'h1, 4'hB, 1'b0, 1'b0, "R6");
    runCase(32'h8000_0000, 32'h1, 4'hA, 1'b0, 1'b0, "R6");
    // R7 carry kept
    runCase(32'h1, 32'h1, 4'h0, 1'b1, 1'b0, "R7");
    runCase(32'h3, 32'h5, 4'hD, 1'b1, 1'b1, "R7");
    // R8 shift boundaries
    runCase(32'h0000_0001, 32'd32, 4'h2, 1'b0, 1'b0, "R8");
    runCase(32'hFFFF_FFFF, 32'd33, 4'h2, 1'b1, 1'b0, "R8");
    runCase(32'h8000_0000, 32'd32, 4'h3, 1'b0, 1'b0, "R8");
    runCase(32'h8000_00F0, 32'd5, 4'h3, 1'b0, 1'b0, "R8");
    // R9 arithmetic right
    runCase(32'h8000_0000, 32'd40, 4'h4, 1'b0, 1'b0, "R9");
    runCase(32'h7000_0000, 32'd255, 4'h4, 1'b1, 1'b0, "R9");
    // R10 rotate
    runCase(32'h8000_0001, 32'd32, 4'h7, 1'b0, 1'b0, "R10");
    runCase(32'h1234_5678, 32'd64, 4'h7, 1'b1, 1'b0, "R10");
    runCase(32'h0000_0008, 32'd4, 4'h7, 1'b0, 1'b0, "R10");
    // R11 zero distance, upper bits ignored
    runCase(32'hDEAD_BEEF, 32'h0000_0100, 4'h2, 1'b1, 1'b0, "R11");
    runCase(32'hDEAD_BEEF, 32'hFFFF_FF00, 4'h7, 1'b0, 1'b1, "R11");
    // R12 multiply truncation
    runCase(32'h0001_0000, 32'h0001_0000, 4'hD, 1'b0, 1'b0, "R12");
    runCase(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hD, 1'b0, 1'b0, "R12");
    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      op = 4'($urandom() % 16);
      a  = $urandom();
      b  = $urandom();
      if ((k % 4) == 0) a = a & 32'h0000_000F;
      if ((k % 4) == 1) b = a;
      if ((k % 3) == 0) b[7:0] = 8'($urandom() % 70);
      runCase(a, b, op, 1'($urandom()), 1'($urandom()), tagFor(op));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule